// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home directory for a group of memory blocks in a distributed shared-memory machine with `NODES` caching nodes. It keeps three things for each block: a coherence state (Uncached, Shared or Exclusive), a sharer vector with one bit per node, and the block's memory word. Remote nodes send it read-miss, write-miss and write-back requests. The controller answers with data replies, sends invalidates to sharers, and sends fetch or fetch-and-invalidate messages to the current owner. It then takes the data the owner returns and writes it into its own memory.

All message traffic uses valid/ready ports. A message moves on a rising edge where both valid and ready are high. Once the controller raises `fwd_valid` or `rsp_valid`, it holds that output and its payload steady until the matching ready is sampled high. The controller handles one request at a time from acceptance to completion. `req_ready` stays low for the whole of that time, including while it waits for owner data, so a requester sees back-pressure instead of losing a request.

Top module: `dir_home`

## Requirements
- R1: A block is always in one of three states. While a block is Exclusive, its sharer vector has exactly one bit set, and the index of that bit is the owner.
- R2: A read miss (`req_op`=0) to an Uncached block replies with the memory word. The block becomes Shared, with the requester as its only sharer.
- R3: A write miss (`req_op`=1) to an Uncached block replies with the memory word. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block replies with the memory word and adds the requester to the sharer vector.
- R5: A write miss to a Shared block sends an invalidate (`fwd_type`=0) to every sharer except the requester, then replies with the memory word. The block becomes Exclusive, owned by the requester. If the requester is the only sharer, no invalidate is sent.
- R6: A read miss to an Exclusive block sends a fetch (`fwd_type`=1) to the owner and waits for the owner's data. That data is written to memory and forwarded to the requester. The old owner and the requester become the sharers, and the block becomes Shared.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (`fwd_type`=2) to the owner. The returned data is written to memory and replied to the requester. The requester becomes the sole owner, and the block stays Exclusive.
- R8: A write-back (`req_op`=2) from the owner of an Exclusive block writes `req_data` to memory, clears the sharer vector and makes the block Uncached, with no reply. A write-back from any other node, or to a block that is not Exclusive, has no effect.
- R9: Invalidates go out one per accepted message in ascending node order. The data reply follows the last invalidate.
- R10: From acceptance until its data reply is taken, `req_ready` is low. This includes the cycles spent waiting for owner data.
- R11: While `fwd_ready` or `rsp_ready` is low, the pending forward or reply message is held with unchanged payload.
- R12: After reset every block is Uncached with no sharers, and the memory word of block b is `MEM_BASE + b`. `req_ready` is high and no message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Target block |
| req_data | input | DW | Write-back data |
| fwd_valid | output | 1 | Invalidate or fetch message pending |
| fwd_ready | input | 1 | Network takes the forward message |
| fwd_type | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| fwd_node | output | $clog2(NODES) | Destination node |
| fwd_blk | output | $clog2(BLOCKS) | Block concerned |
| own_valid | input | 1 | Owner data present |
| own_ready | output | 1 | Controller waiting for owner data |
| own_data | input | DW | Data returned by the owner |
| rsp_valid | output | 1 | Data reply pending |
| rsp_ready | input | 1 | Network takes the reply |
| rsp_node | output | $clog2(NODES) | Reply destination |
| rsp_data | output | DW | Reply data |

## Verification
The hardest situation to reach is a block that moves through Exclusive ownership more than once. In that case the fetched data must land in memory and appear again on a later miss from a different node. The vector table therefore drives one block through a single chain: Uncached, then several sharers, then a write that invalidates them, then a fetch, a fetch-and-invalidate, and finally an owner write-back. Each step's expected data depends on what the owner returned in an earlier step. Directed tests then hold `fwd_ready` and `rsp_ready` low on a fresh block, to show that messages are held and requests are stalled.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {BLK_UNC = 2'd0, BLK_SHR = 2'd1, BLK_EXC = 2'd2} blk_st_t;
  typedef enum logic [2:0] {S_IDLE, S_INVAL, S_FETCH, S_WAIT, S_REPLY} fsm_t;
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_WB = 2'd2;
  localparam logic [1:0] FW_INV   = 2'd0;
  localparam logic [1:0] FW_FETCH = 2'd1;
  localparam logic [1:0] FW_FINV  = 2'd2;
endpackage

// File: rtl/dir_pick.sv
// Lowest set bit of a vector -> its index (0 when empty)
module dir_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
// Per-block directory entries and memory words
module dir_store
  import dir_pkg::*;
#(
  parameter int          BLOCKS   = 8,
  parameter int          NODES    = 4,
  parameter int          DW       = 32,
  parameter logic [31:0] MEM_BASE = 32'hA000_0000,
  localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_blk,
  output blk_st_t          rd_state,
  output logic [NODES-1:0] rd_shr,
  output logic [DW-1:0]    rd_data,
  input  logic             dwe,
  input  logic [BW-1:0]    dw_blk,
  input  blk_st_t          dw_state,
  input  logic [NODES-1:0] dw_shr,
  input  logic             mwe,
  input  logic [BW-1:0]    mw_blk,
  input  logic [DW-1:0]    mw_data
);
  blk_st_t          st_q  [BLOCKS];
  logic [NODES-1:0] shr_q [BLOCKS];
  logic [DW-1:0]    mem_q [BLOCKS];

  for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[b]  <= BLK_UNC;
        shr_q[b] <= '0;
        mem_q[b] <= DW'(MEM_BASE) + DW'(b);
      end else begin
        if (dwe && dw_blk == BW'(b)) begin
          st_q[b]  <= dw_state;
          shr_q[b] <= dw_shr;
        end
        if (mwe && mw_blk == BW'(b)) mem_q[b] <= mw_data;
      end
    end
  end

  assign rd_state = st_q[rd_blk];
  assign rd_shr   = shr_q[rd_blk];
  assign rd_data  = mem_q[rd_blk];

  AST_EXC_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (dwe && dw_state == BLK_EXC) |-> $countones(dw_shr) == 1); // R1
  AST_UNC_NO_SHR: assert property (@(posedge clk) disable iff (!rst_n)
    (dwe && dw_state == BLK_UNC) |-> dw_shr == '0); // R8
endmodule

// File: rtl/dir_home.sv
module dir_home
  import dir_pkg::*;
#(
  parameter int          NODES    = 4,
  parameter int          BLOCKS   = 8,
  parameter int          DW       = 32,
  parameter logic [31:0] MEM_BASE = 32'hA000_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_op,
  input  logic [$clog2(NODES)-1:0]  req_node,
  input  logic [$clog2(BLOCKS)-1:0] req_blk,
  input  logic [DW-1:0]             req_data,
  output logic                      fwd_valid,
  input  logic                      fwd_ready,
  output logic [1:0]                fwd_type,
  output logic [$clog2(NODES)-1:0]  fwd_node,
  output logic [$clog2(BLOCKS)-1:0] fwd_blk,
  input  logic                      own_valid,
  output logic                      own_ready,
  input  logic [DW-1:0]             own_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [$clog2(NODES)-1:0]  rsp_node,
  output logic [DW-1:0]             rsp_data
);
  localparam int NW = $clog2(NODES);
  localparam int BW = $clog2(BLOCKS);

  fsm_t             st;
  logic [NW-1:0]    cur_node, owner_q;
  logic [BW-1:0]    cur_blk;
  logic [NODES-1:0] inv_mask;
  logic             fetch_inv;
  logic [DW-1:0]    rsp_q;

  blk_st_t          rd_state;
  logic [NODES-1:0] rd_shr;
  logic [DW-1:0]    rd_data;
  logic             dwe, mwe;
  logic [BW-1:0]    dw_blk, mw_blk;
  blk_st_t          dw_state;
  logic [NODES-1:0] dw_shr;
  logic [DW-1:0]    mw_data;
  logic [NW-1:0]    own_idx, inv_idx;

  wire [NODES-1:0] req_bit   = NODES'(1) << req_node;
  wire [NODES-1:0] cur_bit   = NODES'(1) << cur_node;
  wire [NODES-1:0] owner_bit = NODES'(1) << owner_q;
  wire [NODES-1:0] inv_next  = inv_mask & ~(NODES'(1) << inv_idx);
  wire             accept    = (st == S_IDLE) && req_valid;

  dir_store #(.BLOCKS(BLOCKS), .NODES(NODES), .DW(DW), .MEM_BASE(MEM_BASE)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_blk((st == S_IDLE) ? req_blk : cur_blk),
    .rd_state(rd_state), .rd_shr(rd_shr), .rd_data(rd_data),
    .dwe(dwe), .dw_blk(dw_blk), .dw_state(dw_state), .dw_shr(dw_shr),
    .mwe(mwe), .mw_blk(mw_blk), .mw_data(mw_data)
  );

  // Owner of an Exclusive block: its single sharer bit
  dir_pick #(.N(NODES)) u_owner (.vec(rd_shr),   .idx(own_idx));
  // Next invalidate target: lowest remaining sharer
  dir_pick #(.N(NODES)) u_inv   (.vec(inv_mask), .idx(inv_idx));

  // Directory and memory update
  always_comb begin
    dwe      = 1'b0;
    mwe      = 1'b0;
    dw_blk   = cur_blk;
    mw_blk   = cur_blk;
    dw_state = BLK_UNC;
    dw_shr   = '0;
    mw_data  = own_data;
    if (accept) begin
      dw_blk = req_blk;
      mw_blk = req_blk;
      unique case (req_op)
        OP_RD: begin
          if (rd_state == BLK_UNC) begin
            dwe = 1'b1; dw_state = BLK_SHR; dw_shr = req_bit;
          end else if (rd_state == BLK_SHR) begin
            dwe = 1'b1; dw_state = BLK_SHR; dw_shr = rd_shr | req_bit;
          end
        end
        OP_WR: begin
          if (rd_state != BLK_EXC) begin
            dwe = 1'b1; dw_state = BLK_EXC; dw_shr = req_bit;
          end
        end
        OP_WB: begin
          if (rd_state == BLK_EXC && rd_shr == req_bit) begin
            dwe = 1'b1; dw_state = BLK_UNC; dw_shr = '0;
            mwe = 1'b1; mw_data = req_data;
          end
        end
        default: ;
      endcase
    end else if (st == S_WAIT && own_valid) begin
      dwe      = 1'b1;
      dw_state = fetch_inv ? BLK_EXC : BLK_SHR;
      dw_shr   = fetch_inv ? cur_bit : (cur_bit | owner_bit);
      mwe      = 1'b1;
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_node  <= '0;
      cur_blk   <= '0;
      owner_q   <= '0;
      inv_mask  <= '0;
      fetch_inv <= 1'b0;
      rsp_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          cur_node <= req_node;
          cur_blk  <= req_blk;
          rsp_q    <= rd_data;
          if (req_op == OP_RD || req_op == OP_WR) begin
            if (rd_state == BLK_EXC) begin
              owner_q   <= own_idx;
              fetch_inv <= (req_op == OP_WR);
              st        <= S_FETCH;
            end else if (req_op == OP_WR && rd_state == BLK_SHR &&
                         (rd_shr & ~req_bit) != '0) begin
              inv_mask <= rd_shr & ~req_bit;
              st       <= S_INVAL;
            end else begin
              st <= S_REPLY;
            end
          end
        end
        S_INVAL: if (fwd_ready) begin
          inv_mask <= inv_next;
          if (inv_next == '0) st <= S_REPLY;
        end
        S_FETCH: if (fwd_ready) st <= S_WAIT;
        S_WAIT: if (own_valid) begin
          rsp_q <= own_data;
          st    <= S_REPLY;
        end
        S_REPLY: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign fwd_valid = (st == S_INVAL) || (st == S_FETCH);
  assign fwd_type  = (st == S_INVAL) ? FW_INV : (fetch_inv ? FW_FINV : FW_FETCH);
  assign fwd_node  = (st == S_INVAL) ? inv_idx : owner_q;
  assign fwd_blk   = cur_blk;
  assign own_ready = (st == S_WAIT);
  assign rsp_valid = (st == S_REPLY);
  assign rsp_node  = cur_node;
  assign rsp_data  = rsp_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_node))); // R11
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_node) && $stable(fwd_type))); // R11
  AST_INV_SKIP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_type == FW_INV) |-> fwd_node != rsp_node); // R9
  AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_type == FW_INV && $past(fwd_valid && fwd_ready && fwd_type == FW_INV))
      |-> fwd_node > $past(fwd_node)); // R9
  AST_STALL_ON_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    own_ready |-> !req_ready); // R10
  AST_ONE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fwd_valid)); // R9
endmodule

// File: tb/sim_dir_home.sv
`timescale 1ns/1ps
module sim_dir_home;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, fwd_ready = 1'b0, own_valid = 1'b0, rsp_ready = 1'b0;
  logic        req_ready, fwd_valid, own_ready, rsp_valid;
  logic [1:0]  req_op = '0, fwd_type;
  logic [1:0]  req_node = '0, fwd_node, rsp_node;
  logic [2:0]  req_blk = '0, fwd_blk;
  logic [31:0] req_data = '0, own_data = '0, rsp_data;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dir_home u0 (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [1:0] op, input logic [1:0] nd,
                          input logic [2:0] bk, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_node = nd; req_blk = bk; req_data = d;
    for (int t = 0; t < 50 && !req_ready; t++) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_fwd(input logic [1:0] ty, input logic [1:0] nd,
                            input logic [2:0] bk, input string rq);
    @(negedge clk);
    for (int t = 0; t < 50 && !fwd_valid; t++) @(negedge clk);
    chk(fwd_valid == 1'b1, rq, "fwd_valid", 32'(fwd_valid), 32'd1);
    chk(fwd_type == ty && fwd_node == nd && fwd_blk == bk, rq, "fwd type/node/blk",
        {22'd0, fwd_type, 3'd0, fwd_node, fwd_blk}, {22'd0, ty, 3'd0, nd, bk});
    fwd_ready = 1'b1;
    @(posedge clk); #1;
    fwd_ready = 1'b0;
  endtask

  task automatic supply_owner(input logic [31:0] d);
    @(negedge clk);
    own_valid = 1'b1; own_data = d;
    for (int t = 0; t < 50 && !own_ready; t++) @(negedge clk);
    @(posedge clk); #1;
    own_valid = 1'b0;
  endtask

  task automatic expect_rsp(input logic [1:0] nd, input logic [31:0] d, input string rq);
    @(negedge clk);
    for (int t = 0; t < 50 && !rsp_valid; t++) @(negedge clk);
    chk(rsp_valid == 1'b1, rq, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_node == nd, rq, "rsp_node", 32'(rsp_node), 32'(nd));
    chk(rsp_data == d, rq, "rsp_data", rsp_data, d);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
  endtask

  // Fields: rq[83:80] op[79:78] node[77:76] blk[75:73] wdata[72:41]
  //         invmask[40:37] fetchkind[36:35] fetchnode[34:33] hasrsp[32] rdata[31:0]
  localparam int NV = 15;
  localparam logic [83:0] TBL [NV] = '{
    {4'd2,  2'd0, 2'd1, 3'd2, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0002}, // R2
    {4'd4,  2'd0, 2'd3, 3'd2, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0002}, // R4
    {4'd4,  2'd0, 2'd0, 3'd2, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0002}, // R4
    {4'd5,  2'd1, 2'd1, 3'd2, 32'h0,         4'h9, 2'd0, 2'd0, 1'b1, 32'hA000_0002}, // R5 R9
    {4'd6,  2'd0, 2'd2, 3'd2, 32'h1234_5678, 4'h0, 2'd1, 2'd1, 1'b1, 32'h1234_5678}, // R6
    {4'd6,  2'd0, 2'd0, 3'd2, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'h1234_5678}, // R6 memory
    {4'd5,  2'd1, 2'd2, 3'd2, 32'h0,         4'h3, 2'd0, 2'd0, 1'b1, 32'h1234_5678}, // R5
    {4'd7,  2'd1, 2'd3, 3'd2, 32'hCAFE_0001, 4'h0, 2'd2, 2'd2, 1'b1, 32'hCAFE_0001}, // R7
    {4'd8,  2'd2, 2'd3, 3'd2, 32'hBEEF_0003, 4'h0, 2'd0, 2'd0, 1'b0, 32'h0},         // R8
    {4'd8,  2'd0, 2'd0, 3'd2, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hBEEF_0003}, // R8
    {4'd3,  2'd1, 2'd2, 3'd5, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0005}, // R3
    {4'd8,  2'd2, 2'd1, 3'd5, 32'hDEAD_0000, 4'h0, 2'd0, 2'd0, 1'b0, 32'h0},         // R8 ignored
    {4'd1,  2'd0, 2'd0, 3'd5, 32'h0000_0055, 4'h0, 2'd1, 2'd2, 1'b1, 32'h0000_0055}, // R1 R8 owner kept
    {4'd12, 2'd0, 2'd3, 3'd4, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0004}, // R12 R2
    {4'd5,  2'd1, 2'd3, 3'd4, 32'h0,         4'h0, 2'd0, 2'd0, 1'b1, 32'hA000_0004}  // R5 sole sharer
  };

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 idle outputs after reset
    chk(req_ready && !rsp_valid && !fwd_valid && !own_ready, "R12", "reset outputs",
        {28'd0, req_ready, rsp_valid, fwd_valid, own_ready}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      string rq;
      v  = TBL[i];
      rq = $sformatf("R%0d", v[83:80]);
      send_req(v[79:78], v[77:76], v[75:73], v[72:41]);
      for (int n = 0; n < 4; n++)
        if (v[37+n]) expect_fwd(2'd0, 2'(n), v[75:73], rq);
      if (v[36:35] != 2'd0) begin
        expect_fwd(v[36:35], v[34:33], v[75:73], rq);
        @(negedge clk);
        chk(!req_ready, "R10", "req_ready while awaiting owner", 32'(req_ready), 32'd0);
        supply_owner(v[72:41]);
      end
      if (v[32]) expect_rsp(v[77:76], v[31:0], rq);
      else begin
        repeat (2) @(negedge clk);
        chk(req_ready && !rsp_valid && !fwd_valid, rq, "write-back produces no message",
            {29'd0, req_ready, rsp_valid, fwd_valid}, 32'h4);
      end
    end

    // R11 reply back-pressure on fresh block 7 (also R12 initial word)
    send_req(2'd0, 2'd1, 3'd7, 32'h0);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(rsp_valid && rsp_data == 32'hA000_0007, "R11", "reply held", rsp_data, 32'hA000_0007);
      chk(!req_ready, "R10", "req_ready during held reply", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    expect_rsp(2'd1, 32'hA000_0007, "R11");

    // R11 forward back-pressure: write by node 2 invalidates node 1
    send_req(2'd1, 2'd2, 3'd7, 32'h0);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(fwd_valid && fwd_node == 2'd1 && fwd_type == 2'd0, "R11", "invalidate held",
          {30'd0, fwd_node}, 32'd1);
      @(negedge clk);
    end
    expect_fwd(2'd0, 2'd1, 3'd7, "R9");
    expect_rsp(2'd2, 32'hA000_0007, "R5");

    // R1 block 7 now owned by node 2 only: a read fetches from node 2
    send_req(2'd0, 2'd0, 3'd7, 32'h0);
    expect_fwd(2'd1, 2'd2, 3'd7, "R1");
    supply_owner(32'h7777_0007);
    expect_rsp(2'd0, 32'h7777_0007, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule